// File: doc/BRIEF.md
# System-Management RAM Access Control Register

This block holds a single byte-wide control register that decides how system-management RAM may be reached. Four control bits live in it: an open bit that exposes the protected RAM to ordinary accesses, a closed bit, a global enable for the protected RAM, and a lock bit. Firmware reaches the register through a plain configuration byte port. The port carries an address, a write strobe, write data, a read strobe and read data. The four bits also drive dedicated output pins, so downstream memory-gating logic can use them directly.

The lock bit is sticky. Writing a 1 to it clears the open bit in the same write. From then on the open bit stays at 0 and the global enable keeps its current value. Only a reset releases the lock. The usual sequence has two writes. The first clears open and lock and sets closed and enable. The second sets lock. The configuration port is a control interface, not a data stream. It has no handshake: every strobe takes effect in the cycle it is presented.

Top module: `smram_ctl`

## Requirements
- R1: After reset, open, closed, global enable and lock are all 0, and a read of the register returns the fixed upper nibble with a zero lower nibble.
- R2: While unlocked, a write sets the open bit (bit 0) to the written value, provided bit 3 of that write is 0. The new value shows on the output and in readback from the next cycle on.
- R3: A write with bit 3 (lock) set forces the open bit to 0, whatever value that write carries in bit 0.
- R4: While locked, writing 1 to bit 0 has no effect, and the open bit keeps reading 0.
- R5: The lock bit can only be set by writing 1. Writing 0 to it while it is set is ignored.
- R6: Global enable (bit 2) follows writes while unlocked. The write that sets lock also loads bit 2. After that, bit 2 is frozen until reset.
- R7: The closed bit (bit 1) takes the written value on every write to the register, locked or not.
- R8: A write strobe whose address differs from the register address changes no bit. A read at any other address returns 0x00.
- R9: When the read strobe is high with the register address, read data shows {fixed nibble, lock, enable, closed, open} in that same cycle. When the read strobe is low, read data is 0x00.
- R10: Reset clears the lock, and the open bit can then be written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the only way to clear the lock |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 8 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid in the cycle of cfg_rd |
| smram_open | output | 1 | Protected RAM open to ordinary accesses |
| smram_closed | output | 1 | Protected RAM closed to data accesses |
| smram_gen | output | 1 | Global enable for protected RAM |
| smram_locked | output | 1 | Lock state |

## Verification
The state lives in four flops, and each one drives a pin directly. A wrong lock or open state therefore shows at the outputs on the cycle after the write that caused it. It also shows in the readback of any later read. A lock that fails to stick shows up as soon as the bench writes a 0 to lock, or a 1 to open, while locked. A frozen enable that moves shows in the very next readback. A decoder that matches the wrong address shows in two ways: register bits change after a write to a foreign address, or a foreign read returns something other than zero.

// File: rtl/smram_ctl_pkg.sv
package smram_ctl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CTL_W    = 4;
  localparam int unsigned FIXED_W  = DATA_W - CTL_W;
  localparam int unsigned BIT_OPEN = 0;
  localparam int unsigned BIT_CLS  = 1;
  localparam int unsigned BIT_GEN  = 2;
  localparam int unsigned BIT_LOCK = 3;

  typedef struct packed {
    logic lock;
    logic gen;
    logic closed;
    logic open;
  } smram_bits_t;
endpackage

// File: rtl/smram_addr_dec.sv
module smram_addr_dec #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit_wr,
  output logic              hit_rd
);
  logic match;
  always_comb begin
    match  = (addr == REG_ADDR);
    hit_wr = wr && match;
    hit_rd = rd && match;
  end
endmodule

// File: rtl/smram_lock_ctrl.sv
module smram_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic set_req,
  output logic locked_q,
  output logic locking_now
);
  always_comb locking_now = hit_wr && set_req && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked_q <= 1'b0;
    else if (locking_now) locked_q <= 1'b1;
  end
endmodule

// File: rtl/smram_field_regs.sv
module smram_field_regs
  import smram_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit_wr,
  input  smram_bits_t wbits,
  input  logic        locked_q,
  output logic        open_q,
  output logic        closed_q,
  output logic        gen_q
);
  logic open_d, gen_d, closed_d;

  always_comb begin
    open_d   = open_q;
    gen_d    = gen_q;
    closed_d = closed_q;
    if (hit_wr) begin
      closed_d = wbits.closed;
      if (!locked_q) begin
        gen_d  = wbits.gen;
        open_d = wbits.open && !wbits.lock;
      end
    end
    if (locked_q) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      closed_q <= 1'b0;
      gen_q    <= 1'b0;
    end else begin
      open_q   <= open_d;
      closed_q <= closed_d;
      gen_q    <= gen_d;
    end
  end
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h48,
  parameter logic [FIXED_W-1:0] FIXED_HI = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rd,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              smram_open,
  output logic              smram_closed,
  output logic              smram_gen,
  output logic              smram_locked
);
  logic        hit_wr, hit_rd, locking_now;
  smram_bits_t wbits, cur;
  logic        unused_hi;

  always_comb begin
    wbits     = smram_bits_t'(cfg_wdata[CTL_W-1:0]);
    unused_hi = &{1'b0, cfg_wdata[DATA_W-1:CTL_W], locking_now};
  end

  smram_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
    .addr(cfg_addr), .wr(cfg_wr), .rd(cfg_rd),
    .hit_wr(hit_wr), .hit_rd(hit_rd)
  );

  smram_lock_ctrl lock_i (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .set_req(wbits.lock),
    .locked_q(smram_locked), .locking_now(locking_now)
  );

  smram_field_regs fields_i (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .wbits(wbits),
    .locked_q(smram_locked), .open_q(smram_open),
    .closed_q(smram_closed), .gen_q(smram_gen)
  );

  always_comb begin
    cur.lock   = smram_locked;
    cur.gen    = smram_gen;
    cur.closed = smram_closed;
    cur.open   = smram_open;
    cfg_rdata  = hit_rd ? {FIXED_HI, cur} : '0;
  end
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h48,
  parameter logic [3:0] FIXED_HI = 4'h2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic              cfg_rd,
  input logic [7:0]        cfg_rdata,
  input logic              smram_open,
  input logic              smram_closed,
  input logic              smram_gen,
  input logic              smram_locked
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    smram_locked |=> smram_locked); // R5
  AST_OPEN_LOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    smram_locked |-> !smram_open); // R4
  AST_LOCK_WRITE_CLEARS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == REG_ADDR && cfg_wdata[3]) |=> !smram_open); // R3
  AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    smram_locked |=> $stable(smram_gen)); // R6
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr != REG_ADDR) |=>
      $stable({smram_open, smram_closed, smram_gen, smram_locked})); // R8
  AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == REG_ADDR && !smram_locked && !cfg_wdata[3]) |=>
      (smram_open == $past(cfg_wdata[0]))); // R2
  AST_CLOSED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == REG_ADDR) |=> (smram_closed == $past(cfg_wdata[1]))); // R7
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |-> (cfg_rdata == 8'h00)); // R9
  AST_RDATA_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == REG_ADDR) |-> (cfg_rdata[7:4] == FIXED_HI)); // R9
endmodule

bind smram_ctl smram_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .FIXED_HI(FIXED_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
  .smram_open(smram_open), .smram_closed(smram_closed),
  .smram_gen(smram_gen), .smram_locked(smram_locked)
);

// File: tb/smram_ctl_tb_top.sv
`timescale 1ns/1ps
module smram_ctl_tb_top;
  localparam logic [7:0] REG = 8'h48;
  localparam logic [7:0] HI  = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_rd = 1'b0;
  logic [7:0] cfg_rdata;
  logic       smram_open, smram_closed, smram_gen, smram_locked;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  smram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .smram_open(smram_open), .smram_closed(smram_closed),
    .smram_gen(smram_gen), .smram_locked(smram_locked)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); cfg_addr = a; cfg_rd = 1'b1;
    #1 chk(req, cfg_rdata, exp);
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, smram_locked, smram_gen, smram_closed, smram_open};
  endfunction

  task automatic t_reset_state();
    do_reset();
    #1 chk("R1 pins", pins(), 8'h00);
    rd_chk("R1 readback", REG, HI);
    #1 chk("R9 idle rdata", cfg_rdata, 8'h00);
  endtask

  task automatic t_open_toggle();
    wr(REG, 8'h01);
    #1 chk("R2 open pin set", pins(), 8'h01);
    rd_chk("R2 readback set", REG, HI | 8'h01);
    wr(REG, 8'h00);
    rd_chk("R2 readback clear", REG, HI);
  endtask

  task automatic t_foreign();
    wr(8'h49, 8'hFF);
    #1 chk("R8 foreign write pins", pins(), 8'h00);
    rd_chk("R8 foreign read", 8'h47, 8'h00);
    rd_chk("R8 register untouched", REG, HI);
  endtask

  task automatic t_lock_flow();
    wr(REG, 8'h07);
    rd_chk("R6 setup open+closed+gen", REG, HI | 8'h07);
    wr(REG, 8'h0F);
    #1 chk("R3 lock clears open", pins(), 8'h0E);
    rd_chk("R3 readback", REG, HI | 8'h0E);
    wr(REG, 8'h09);
    rd_chk("R4 R6 R7 open ignored gen frozen closed cleared", REG, HI | 8'h0C);
    wr(REG, 8'h00);
    rd_chk("R5 lock write-0 ignored", REG, HI | 8'h0C);
    wr(REG, 8'h03);
    rd_chk("R7 closed set while locked", REG, HI | 8'h0E);
  endtask

  task automatic t_reset_unlocks();
    do_reset();
    rd_chk("R10 reset clears lock", REG, HI);
    wr(REG, 8'h01);
    rd_chk("R10 open writable again", REG, HI | 8'h01);
  endtask

  task automatic t_lock_gen_low();
    wr(REG, 8'h0C);
    rd_chk("R6 lock loads gen=1", REG, HI | 8'h0C);
    do_reset();
    wr(REG, 8'h08);
    rd_chk("R6 lock with gen=0", REG, HI | 8'h08);
    wr(REG, 8'h04);
    rd_chk("R6 gen stays 0 after lock", REG, HI | 8'h08);
  endtask

  initial begin
    t_reset_state();
    t_open_toggle();
    t_foreign();
    t_lock_flow();
    t_reset_unlocks();
    t_lock_gen_low();
    done = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule